// File: doc/BRIEF.md
# Coprocessor Escape and Wait Sequencer

This block sits in the decode/execute path of a CPU that offloads floating-point work to an external math coprocessor. For every issued instruction it looks at the first opcode byte and the WAIT decode. It then either forwards a coprocessor escape to the coprocessor, raises a "coprocessor not available" exception (vector 7), or raises a "coprocessor error" exception (vector 16). A WAIT stalls the pipeline while the coprocessor reports busy. After that it picks up any error the coprocessor left pending.

The block owns the four coprocessor control bits:

- `emulate`: escapes are trapped so that software can emulate them.
- `monitor`: a coprocessor is present, so WAIT must honour `dirty`.
- `dirty`: the coprocessor context may belong to another task.
- `wide`: selects the 32-bit transfer protocol instead of the 16-bit one.

A task switch sets `dirty`. A privileged clear strobe resets it. A privileged write loads all four bits. Software at any other privilege level gets a general-protection request instead. The protocol bit is captured from the coprocessor error pin while reset is held.

Top module: `cpesc_seq`

## Requirements
- R1: An issued non-WAIT instruction is an escape exactly when `opByte[7:3]` equals 5'b11011. An escape that passes every check gives a one-cycle `dispatch` pulse in the cycle after issue. Any other byte produces neither dispatch nor exception.
- R2: An escape issued while `emulate` is set raises `excValid` with `excVector` = 7 in the cycle after issue, and does not dispatch.
- R3: An escape issued while `emulate` is clear and `dirty` is set raises exception 7 and does not dispatch.
- R4: An escape issued with `errCheck` high, `emulate` and `dirty` clear, and `errorN` low raises exception 16 without dispatch. With `errCheck` low, `errorN` has no effect. The checks are applied in the order emulate, dirty, error, and only the first failing check is reported.
- R5: A WAIT issued while both `monitor` and `dirty` are set raises exception 7 in the cycle after issue, with no stall. With `monitor` clear, `dirty` is not tested by WAIT.
- R6: Any other WAIT drives `stall` high from the cycle after issue for as long as `busyN` is sampled low. In the cycle after `busyN` is first sampled high, `stall` drops, and exception 16 is raised if and only if `errorN` was sampled low on that same edge.
- R7: `taskSwitch` sets `dirty`. `clearDirtyReq` at privilege 0 clears it. When both are high in the same cycle, the task switch wins.
- R8: `ctlWrEn` at privilege 0 loads `ctlWrData` into the control bits on the next edge. The bit mapping is bit 0 `emulate`, bit 1 `monitor`, bit 2 `dirty`, bit 3 `wide`. `ctlBits` shows the bits in the same order, and `wideProto` mirrors bit 3.
- R9: `ctlWrEn` or `clearDirtyReq` at a nonzero `cpl` leaves the control bits unchanged and gives a one-cycle `gpFault` in the next cycle.
- R10: While `rstN` is low, `emulate`, `monitor` and `dirty` are cleared, all pulse outputs and `stall` are low, and `wide` is loaded with the inverse of `errorN`.
- R11: `dispatch` and `excValid` are never high together. `excVector` is 7 or 16 whenever `excValid` is high. Issues presented while `stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| opValid | input | 1 | Instruction issue strobe |
| opByte | input | 8 | First opcode byte of the issued instruction |
| isWait | input | 1 | Issued instruction is WAIT |
| errCheck | input | 1 | Escape form that tests the error pin before dispatch |
| busyN | input | 1 | Coprocessor busy, active low |
| errorN | input | 1 | Coprocessor error, active low |
| taskSwitch | input | 1 | Task switch pulse |
| clearDirtyReq | input | 1 | Request to clear the dirty bit |
| ctlWrEn | input | 1 | Control-bit write strobe |
| ctlWrData | input | 4 | Control-bit write value |
| cpl | input | 2 | Current privilege level |
| dispatch | output | 1 | Forward escape to coprocessor, one-cycle pulse |
| excValid | output | 1 | Exception request, one-cycle pulse |
| excVector | output | 5 | Exception vector (7 or 16) |
| gpFault | output | 1 | General-protection request for a privileged access |
| stall | output | 1 | WAIT is holding the pipeline |
| wideProto | output | 1 | 32-bit coprocessor protocol selected |
| ctlBits | output | 4 | Current control bits |

## Verification
Several properties are checked by assertions on every cycle:

- dispatch and exception are mutually exclusive, and the vector is always legal;
- an emulate trap blocks dispatch;
- a faulting WAIT never stalls;
- a stall persists while busy is low;
- an unprivileged access both raises a protection request and leaves the bits stable.

Other behaviour can only be shown by the bench's sweeps:

- the full 256-byte escape decode;
- the full priority order among the three escape checks, across every flag combination;
- the busy-then-error sampling of WAIT for varying busy lengths;
- the capture of the protocol bit under both error-pin levels at reset.

// File: rtl/cpesc_pkg.sv
package cpesc_pkg;
  localparam int unsigned OP_W  = 8;
  localparam int unsigned ESC_W = 5;
  localparam int unsigned VEC_W = 5;
  localparam int unsigned CPL_W = 2;
  localparam int unsigned CTL_W = 4;

  localparam logic [ESC_W-1:0] ESC_TAG     = 5'b11011;
  localparam logic [VEC_W-1:0] VEC_UNAVAIL = 5'd7;
  localparam logic [VEC_W-1:0] VEC_CPERR   = 5'd16;

  // control bits, msb first: wide, dirty, monitor, emulate
  typedef struct packed {
    logic wide;
    logic dirty;
    logic monitor;
    logic emulate;
  } ctlBits_t;

  // strobes from control to the register datapath
  typedef struct packed {
    logic     loadAll;
    logic     clearDirty;
    logic     setDirty;
    ctlBits_t loadVal;
  } ctlStrobe_t;

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_HOLD = 1'b1} seqState_t;
endpackage

// File: rtl/cpesc_dp.sv
module cpesc_dp
  import cpesc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       errorN,
  input  ctlStrobe_t strobe,
  output ctlBits_t   ctl
);
  ctlBits_t ctlNxt;

  always_comb begin
    ctlNxt = ctl;
    if (strobe.loadAll)    ctlNxt = strobe.loadVal;
    if (strobe.clearDirty) ctlNxt.dirty = 1'b0;
    if (strobe.setDirty)   ctlNxt.dirty = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl.emulate <= 1'b0;
      ctl.monitor <= 1'b0;
      ctl.dirty   <= 1'b0;
      ctl.wide    <= ~errorN;
    end else begin
      ctl <= ctlNxt;
    end
  end

  // R7: a task switch always leaves the dirty bit set
  p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDirty |=> ctl.dirty);

  // R8: without a load, the protocol bit holds
  p_wide_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadAll |=> $stable(ctl.wide));
endmodule

// File: rtl/cpesc_ctrl.sv
module cpesc_ctrl
  import cpesc_pkg::*;
#(
  parameter int unsigned OpW  = OP_W,
  parameter int unsigned CplW = CPL_W,
  parameter int unsigned VecW = VEC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OpW-1:0]  opByte,
  input  logic            isWait,
  input  logic            errCheck,
  input  logic            busyN,
  input  logic            errorN,
  input  logic            taskSwitch,
  input  logic            clearDirtyReq,
  input  logic            ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic [CplW-1:0] cpl,
  input  logic            emulateOn,
  input  logic            monitorOn,
  input  logic            dirtyOn,
  output ctlStrobe_t      strobe,
  output logic            dispatch,
  output logic            excValid,
  output logic [VecW-1:0] excVector,
  output logic            gpFault,
  output logic            stall
);
  localparam int unsigned TagLsb = OpW - ESC_W;

  seqState_t       state, stateNxt;
  logic            privOk, isEsc, accept;
  logic            dispNxt, excNxt, gpNxt;
  logic [VecW-1:0] vecNxt;

  assign privOk = (cpl == '0);
  assign isEsc  = (opByte[OpW-1:TagLsb] == ESC_TAG);
  assign accept = opValid && (state == SEQ_IDLE);
  assign stall  = (state == SEQ_HOLD);

  always_comb begin
    strobe.loadAll    = ctlWrEn && privOk;
    strobe.clearDirty = clearDirtyReq && privOk;
    strobe.setDirty   = taskSwitch;
    strobe.loadVal    = ctlBits_t'(ctlWrData);
  end

  assign gpNxt = (ctlWrEn || clearDirtyReq) && !privOk;

  always_comb begin
    stateNxt = state;
    dispNxt  = 1'b0;
    excNxt   = 1'b0;
    vecNxt   = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (accept && isWait) begin
          if (monitorOn && dirtyOn) begin
            excNxt = 1'b1;
            vecNxt = VecW'(VEC_UNAVAIL);
          end else begin
            stateNxt = SEQ_HOLD;
          end
        end else if (accept && isEsc) begin
          if (emulateOn || dirtyOn) begin
            excNxt = 1'b1;
            vecNxt = VecW'(VEC_UNAVAIL);
          end else if (errCheck && !errorN) begin
            excNxt = 1'b1;
            vecNxt = VecW'(VEC_CPERR);
          end else begin
            dispNxt = 1'b1;
          end
        end
      end
      SEQ_HOLD: begin
        if (busyN) begin
          stateNxt = SEQ_IDLE;
          if (!errorN) begin
            excNxt = 1'b1;
            vecNxt = VecW'(VEC_CPERR);
          end
        end
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      dispatch  <= 1'b0;
      excValid  <= 1'b0;
      excVector <= '0;
      gpFault   <= 1'b0;
    end else begin
      state     <= stateNxt;
      dispatch  <= dispNxt;
      excValid  <= excNxt;
      excVector <= vecNxt;
      gpFault   <= gpNxt;
    end
  end

  // R11: one outcome at a time
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(dispatch && excValid));

  // R11: only the two legal vectors
  p_vec_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excVector == VecW'(VEC_UNAVAIL) || excVector == VecW'(VEC_CPERR)));

  // R2: emulate trap blocks dispatch
  p_emul_trap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !isWait && isEsc && emulateOn) |=>
      (excValid && excVector == VecW'(VEC_UNAVAIL) && !dispatch));

  // R5: a faulting WAIT never stalls
  p_wait_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isWait && monitorOn && dirtyOn) |=> (excValid && !stall));

  // R6: stall persists while busy is sampled low
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !busyN) |=> (stall && !excValid));

  // R9: unprivileged access raises a protection request
  p_gp_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlWrEn || clearDirtyReq) && cpl != '0) |=> gpFault);
endmodule

// File: rtl/cpesc_seq.sv
module cpesc_seq
  import cpesc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opByte,
  input  logic             isWait,
  input  logic             errCheck,
  input  logic             busyN,
  input  logic             errorN,
  input  logic             taskSwitch,
  input  logic             clearDirtyReq,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic [CPL_W-1:0] cpl,
  output logic             dispatch,
  output logic             excValid,
  output logic [VEC_W-1:0] excVector,
  output logic             gpFault,
  output logic             stall,
  output logic             wideProto,
  output logic [CTL_W-1:0] ctlBits
);
  ctlStrobe_t strobe;
  ctlBits_t   ctl;

  cpesc_ctrl #(.OpW(OP_W), .CplW(CPL_W), .VecW(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .isWait(isWait), .errCheck(errCheck), .busyN(busyN), .errorN(errorN),
    .taskSwitch(taskSwitch), .clearDirtyReq(clearDirtyReq),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .cpl(cpl),
    .emulateOn(ctl.emulate), .monitorOn(ctl.monitor), .dirtyOn(ctl.dirty),
    .strobe(strobe), .dispatch(dispatch), .excValid(excValid),
    .excVector(excVector), .gpFault(gpFault), .stall(stall)
  );

  cpesc_dp u_dp (
    .clk(clk), .rstN(rstN), .errorN(errorN), .strobe(strobe), .ctl(ctl)
  );

  assign ctlBits   = ctl;
  assign wideProto = ctl.wide;

  // R9: unprivileged write or clear leaves the bits untouched
  p_priv_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpl != '0 && !taskSwitch) |=> $stable(ctlBits));
endmodule

// File: tb/cpesc_seq_bench.sv
module cpesc_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0, isWait = 1'b0, errCheck = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic busyN = 1'b1, errorN = 1'b1;
  logic taskSwitch = 1'b0, clearDirtyReq = 1'b0, ctlWrEn = 1'b0;
  logic [3:0] ctlWrData = 4'h0;
  logic [1:0] cpl = 2'd0;
  logic dispatch, excValid, gpFault, stall, wideProto;
  logic [4:0] excVector;
  logic [3:0] ctlBits;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpesc_seq u_cpesc_seq (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .isWait(isWait), .errCheck(errCheck), .busyN(busyN), .errorN(errorN),
    .taskSwitch(taskSwitch), .clearDirtyReq(clearDirtyReq),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .cpl(cpl),
    .dispatch(dispatch), .excValid(excValid), .excVector(excVector),
    .gpFault(gpFault), .stall(stall), .wideProto(wideProto), .ctlBits(ctlBits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b, input logic w, input logic ec);
    @(negedge clk);
    opValid = 1'b1; opByte = b; isWait = w; errCheck = ec;
    @(negedge clk);
    opValid = 1'b0; isWait = 1'b0; errCheck = 1'b0;
  endtask

  task automatic writeCtl(input logic [3:0] d, input logic [1:0] lvl);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d; cpl = lvl;
    @(negedge clk);
    ctlWrEn = 1'b0; cpl = 2'd0;
  endtask

  task automatic doReset(input logic errLevel);
    @(negedge clk);
    rstN = 1'b0; errorN = errLevel;
    repeat (3) @(negedge clk);
    rstN = 1'b1; errorN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset with the error pin low selects the wide protocol
    doReset(1'b0);
    chk("R10 ctlBits", ctlBits, 4'b1000);
    chk("R10 wideProto", wideProto, 1);
    chk("R10 quiet", {dispatch, excValid, gpFault, stall}, 0);

    // R1: full byte sweep with all flags clear
    for (int b = 0; b < 256; b++) begin
      issue(8'(b), 1'b0, 1'b1);
      chk($sformatf("R1 dispatch byte %0d", b), dispatch, ((b >> 3) == 5'b11011) ? 1 : 0);
      chk($sformatf("R1 noexc byte %0d", b), excValid, 0);
    end
    issue(8'hDB, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 dispatch pulse width", dispatch, 0);

    // R2 R3 R4: priority over every flag combination
    for (int c = 0; c < 16; c++) begin
      logic em, ts, ec, en;
      int expDisp, expExc, expVec;
      em = c[0]; ts = c[1]; ec = c[2]; en = c[3];
      writeCtl({1'b1, ts, 1'b0, em}, 2'd0);
      chk("R8 ctl load", ctlBits, {1'b1, ts, 1'b0, em});
      errorN = en;
      issue(8'hDD, 1'b0, ec);
      expDisp = 0; expExc = 1; expVec = 7;
      if (!em && !ts) begin
        if (ec && !en) expVec = 16;
        else begin expExc = 0; expVec = 0; expDisp = 1; end
      end
      chk($sformatf("R2 R3 R4 dispatch combo %0d", c), dispatch, expDisp);
      chk($sformatf("R2 R3 R4 exc combo %0d", c), excValid, expExc);
      if (expExc != 0) chk($sformatf("R4 vector combo %0d", c), excVector, expVec);
      errorN = 1'b1;
    end

    // R5 R6: WAIT across monitor, dirty, error and busy length
    for (int c = 0; c < 16; c++) begin
      logic mon, ts, en;
      int d;
      mon = c[0]; ts = c[1]; en = c[2]; d = c[3] ? 3 : c[0];
      writeCtl({1'b1, ts, mon, 1'b0}, 2'd0);
      errorN = en;
      busyN = (d == 0);
      issue(8'h00, 1'b1, 1'b0);
      if (mon && ts) begin
        chk("R5 wait trap exc", excValid, 1);
        chk("R5 wait trap vector", excVector, 7);
        chk("R5 wait trap nostall", stall, 0);
      end else begin
        chk("R6 stall begins", stall, 1);
        chk("R5 no trap", excValid, 0);
        for (int i = 0; i < d; i++) begin
          if (i == 0) begin opValid = 1'b1; opByte = 8'hD8; end
          @(negedge clk);
          opValid = 1'b0;
          chk("R6 stall while busy", stall, 1);
          chk("R11 issue ignored in stall", dispatch, 0);
          chk("R6 no exc while busy", excValid, 0);
        end
        busyN = 1'b1;
        @(negedge clk);
        chk("R6 stall released", stall, 0);
        chk("R6 error after busy", excValid, en ? 0 : 1);
        if (!en) chk("R6 vector", excVector, 16);
      end
      errorN = 1'b1; busyN = 1'b1;
    end

    // R7: task switch and clear
    writeCtl(4'b0000, 2'd0);
    @(negedge clk); taskSwitch = 1'b1;
    @(negedge clk); taskSwitch = 1'b0;
    chk("R7 task switch sets dirty", ctlBits[2], 1);
    @(negedge clk); clearDirtyReq = 1'b1; cpl = 2'd3;
    @(negedge clk); clearDirtyReq = 1'b0; cpl = 2'd0;
    chk("R9 clear at cpl3 gp", gpFault, 1);
    chk("R9 clear at cpl3 ignored", ctlBits, 4'b0100);
    @(negedge clk); clearDirtyReq = 1'b1;
    @(negedge clk); clearDirtyReq = 1'b0;
    chk("R7 clear at cpl0", ctlBits, 4'b0000);
    chk("R9 no gp at cpl0", gpFault, 0);
    @(negedge clk); clearDirtyReq = 1'b1; taskSwitch = 1'b1;
    @(negedge clk); clearDirtyReq = 1'b0; taskSwitch = 1'b0;
    chk("R7 task switch wins", ctlBits[2], 1);

    // R9: unprivileged write
    writeCtl(4'b1011, 2'd1);
    chk("R9 write cpl1 gp", gpFault, 1);
    chk("R9 write cpl1 ignored", ctlBits, 4'b0100);
    @(negedge clk);
    chk("R9 gp pulse width", gpFault, 0);
    writeCtl(4'b1011, 2'd0);
    chk("R8 privileged write", ctlBits, 4'b1011);
    chk("R8 wideProto mirrors bit 3", wideProto, 1);

    // R10: reset with the error pin high selects the narrow protocol
    doReset(1'b1);
    chk("R10 narrow ctlBits", ctlBits, 4'b0000);
    chk("R10 narrow wideProto", wideProto, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule